// File: doc/BRIEF.md
# Single-Wire Echoing Serial Transceiver

This block is a half-duplex serial port that shares one bidirectional pin between a host and a command layer. It watches the pin for NRZ frames and checks the framing of each one. Every good byte goes to the command layer over a valid/ready stream, and the same byte is sent back to the host on the same pin after a fixed idle gap. The host can check the echo for line errors. The command layer can also push its own bytes onto the pin through a second valid/ready stream.

A long low condition on the pin is a break: a start bit followed by eight zero data bits and a low stop position. The block signals a break with a one-cycle pulse. It then drives the pin high for two bit times and sends a break pattern back. Bit timing is a fixed division of the clock. The pin is modelled open-drain style: an output enable, an output value and a sampled input. The enable is high only while the block is sending a frame or forcing the line high.

Stream rules are as follows. On the receive side, `rx_valid` stays high and `rx_data` stays stable until the cycle `rx_ready` is seen high. The line cannot be stalled, so a byte that completes while an earlier one is still waiting is dropped from the stream, although it is still echoed. On the transmit side, a byte is taken in a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` is high only when the port is completely idle: nothing is being received or sent, and no echo or break reply is waiting.

Top module: `sw_echo_xcvr`

## Requirements
- R1: After reset `line_oe`, `rx_valid` and `brk_det` are low and `tx_ready` is high.
- R2: A frame is read as one low start bit, then DATA_BITS data bits with the least significant bit first, then a high stop bit. A good frame puts its data on `rx_data` with `rx_valid` high.
- R3: While `rx_valid` is high and `rx_ready` is low, `rx_valid` stays high and `rx_data` stays unchanged. A byte that completes during that time is not delivered on the stream.
- R4: Each good byte is sent back as a frame with the same layout (start 0, data LSB first, stop 1). Its start bit begins about two bit times after the middle of the received stop bit. `line_oe` stays low during this gap.
- R5: A frame whose data bits are all zero and whose stop position is low is a break. The block then pulses `brk_det` for one cycle and does not assert `rx_valid`. It drives the pin high for two bit times, then drives it low for DATA_BITS+2 bit times, then releases it.
- R6: A frame whose stop position is low but whose data is not all zero causes no `rx_valid`, no `brk_det` and no output on the pin.
- R7: A low pulse that has ended by the middle of the start bit is ignored.
- R8: When `tx_valid` and `tx_ready` are both high in a cycle, the byte is sent at once as a normal frame. `tx_ready` stays low until that frame has finished.
- R9: The receiver ignores the pin from the moment a byte or break is accepted until the reply has finished. `line_oe` is high only while a frame is being sent or the line is being forced high.
- R10: One bit time is BIT_CYCLES clock cycles (256 by default). Received bits are sampled at mid-bit, half a bit time after the falling edge of the start bit and one bit time apart after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the bit-timing reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared pin |
| line_oe | output | 1 | Pin output enable |
| line_out | output | 1 | Level driven on the pin while enabled |
| rx_valid | output | 1 | Received byte available |
| rx_ready | input | 1 | Command layer accepts the received byte |
| rx_data | output | DATA_BITS | Received byte |
| tx_valid | input | 1 | Command layer offers a byte to send |
| tx_ready | output | 1 | Port can accept a byte to send |
| tx_data | input | DATA_BITS | Byte to send |
| brk_det | output | 1 | One-cycle pulse when a break is detected |

## Verification
The assertions check the following on every cycle:
- the receive stream holds its byte while it is stalled;
- the transmitter always begins a frame with a low start bit and holds each bit for a whole bit time;
- no new transmission is started over a running one;
- `tx_ready` never appears while the pin is driven;
- a break pulse always coincides with the forced-high interval;
- the receiver reports nothing in a cycle after it has been disabled.

Only the bench scenarios can show the timing of the gap before an echo, the order of the break reply, and the bit values of echoed frames. The same applies to the rejection of glitches and badly framed bytes, and to the silence of the receiver when the host toggles the line during a gap.

// File: rtl/swe_pkg.sv
package swe_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic [1:0] {CT_IDLE, CT_GAP, CT_FORCE, CT_SEND} ctl_state_e;
endpackage

// File: rtl/swe_rx.sv
module swe_rx
  import swe_pkg::*;
#(
  parameter int BIT_CYCLES = 256,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 line_in,
  output logic                 busy,
  output logic                 done_ok,
  output logic                 done_brk,
  output logic [DATA_BITS-1:0] byte_o
);
  localparam int CNT_W = $clog2(BIT_CYCLES);
  localparam int IDX_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BIT_CYCLES / 2 - 1);
  localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(BIT_CYCLES - 1);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(DATA_BITS - 1);

  rx_state_e            state;
  logic [1:0]           sync_q;
  logic                 s;
  logic                 armed;
  logic [CNT_W-1:0]     cnt;
  logic [IDX_W-1:0]     idx;
  logic [DATA_BITS-1:0] sh;

  assign s      = sync_q[1];
  assign busy   = (state != RX_IDLE);
  assign byte_o = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q   <= 2'b11;
      state    <= RX_IDLE;
      armed    <= 1'b0;
      cnt      <= '0;
      idx      <= '0;
      sh       <= '0;
      done_ok  <= 1'b0;
      done_brk <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], line_in};
      done_ok  <= 1'b0;
      done_brk <= 1'b0;
      if (!en) begin
        state <= RX_IDLE;
        armed <= 1'b0;
      end else begin
        case (state)
          RX_IDLE: begin
            if (s) begin
              armed <= 1'b1;
            end else if (armed) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == HALF_LAST) begin
              cnt <= '0;
              idx <= '0;
              state <= s ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == BIT_LAST) begin
              cnt <= '0;
              sh  <= {s, sh[DATA_BITS-1:1]};
              if (idx == IDX_LAST) state <= RX_STOP;
              else idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == BIT_LAST) begin
              cnt   <= '0;
              state <= RX_IDLE;
              armed <= 1'b0;
              if (s) done_ok <= 1'b1;
              else if (sh == '0) done_brk <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_RX_SILENT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !(done_ok || done_brk)); // R9
endmodule

// File: rtl/swe_tx.sv
module swe_tx #(
  parameter int BIT_CYCLES = 256,
  parameter int DATA_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 brk,
  input  logic [DATA_BITS-1:0] data,
  output logic                 busy,
  output logic                 bit_o
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CNT_W = $clog2(BIT_CYCLES);
  localparam int NB_W  = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BIT_CYCLES - 1);
  localparam logic [NB_W-1:0]  NB_LAST  = NB_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sh;
  logic [CNT_W-1:0]      cnt;
  logic [NB_W-1:0]       nb;

  assign bit_o = sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      cnt  <= '0;
      nb   <= '0;
      busy <= 1'b0;
    end else if (start) begin
      sh   <= brk ? '0 : {1'b1, data, 1'b0};
      cnt  <= '0;
      nb   <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      if (cnt == BIT_LAST) begin
        cnt <= '0;
        sh  <= {1'b1, sh[FRAME_BITS-1:1]};
        if (nb == NB_LAST) busy <= 1'b0;
        else nb <= nb + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !bit_o); // R4
  AST_TX_BIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cnt != '0) |-> $stable(bit_o)); // R10
  AST_TX_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R8
endmodule

// File: rtl/swe_ctl.sv
module swe_ctl
  import swe_pkg::*;
#(
  parameter int BIT_CYCLES = 256,
  parameter int DATA_BITS  = 8,
  parameter int GAP_BITS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_busy,
  input  logic                 rx_ok,
  input  logic                 rx_brk,
  input  logic [DATA_BITS-1:0] rx_byte,
  input  logic                 tx_busy,
  output logic                 rx_en,
  output logic                 tx_start,
  output logic                 tx_brk,
  output logic [DATA_BITS-1:0] tx_byte,
  output logic                 force_hi,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 brk_det
);
  localparam int GAP_CYCLES = GAP_BITS * BIT_CYCLES;
  localparam int GAP_W = $clog2(GAP_CYCLES);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYCLES - 1);

  ctl_state_e           state;
  logic [GAP_W-1:0]     gcnt;
  logic [DATA_BITS-1:0] echo_q;
  logic                 gap_done;

  assign gap_done = (gcnt == GAP_LAST);
  assign rx_en    = (state == CT_IDLE);
  assign force_hi = (state == CT_FORCE);
  assign tx_ready = (state == CT_IDLE) && !rx_busy && !rx_ok && !rx_brk;

  always_comb begin
    tx_start = 1'b0;
    tx_brk   = 1'b0;
    tx_byte  = echo_q;
    case (state)
      CT_IDLE: if (tx_valid && tx_ready) begin
        tx_start = 1'b1;
        tx_byte  = tx_data;
      end
      CT_GAP:   tx_start = gap_done;
      CT_FORCE: begin
        tx_start = gap_done;
        tx_brk   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= CT_IDLE;
      gcnt    <= '0;
      echo_q  <= '0;
      brk_det <= 1'b0;
    end else begin
      brk_det <= 1'b0;
      case (state)
        CT_IDLE: begin
          gcnt <= '0;
          if (rx_ok) begin
            echo_q <= rx_byte;
            state  <= CT_GAP;
          end else if (rx_brk) begin
            brk_det <= 1'b1;
            state   <= CT_FORCE;
          end else if (tx_start) begin
            state <= CT_SEND;
          end
        end
        CT_GAP, CT_FORCE: begin
          gcnt <= gcnt + 1'b1;
          if (gap_done) begin
            gcnt  <= '0;
            state <= CT_SEND;
          end
        end
        CT_SEND: if (!tx_busy) state <= CT_IDLE;
        default: state <= CT_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else if (rx_ok && (!rx_valid || rx_ready)) begin
      rx_valid <= 1'b1;
      rx_data  <= rx_byte;
    end else if (rx_ready) begin
      rx_valid <= 1'b0;
    end
  end

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data))); // R3
  AST_BRK_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |-> force_hi); // R5
  AST_BRK_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rx_brk |=> !$rose(rx_valid)); // R5
  AST_TXRDY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!tx_busy && !force_hi)); // R8
endmodule

// File: rtl/sw_echo_xcvr.sv
module sw_echo_xcvr #(
  parameter int BIT_CYCLES = 256,
  parameter int DATA_BITS  = 8,
  parameter int GAP_BITS   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_in,
  output logic                 line_oe,
  output logic                 line_out,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [DATA_BITS-1:0] rx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [DATA_BITS-1:0] tx_data,
  output logic                 brk_det
);
  logic                 rx_en, rx_busy, rx_ok, rx_brk;
  logic [DATA_BITS-1:0] rx_byte;
  logic                 tx_start, tx_brk, tx_busy, tx_bit, force_hi;
  logic [DATA_BITS-1:0] tx_byte;

  swe_rx #(.BIT_CYCLES(BIT_CYCLES), .DATA_BITS(DATA_BITS)) rx_i (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .line_in(line_in),
    .busy(rx_busy), .done_ok(rx_ok), .done_brk(rx_brk), .byte_o(rx_byte)
  );

  swe_tx #(.BIT_CYCLES(BIT_CYCLES), .DATA_BITS(DATA_BITS)) tx_i (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .brk(tx_brk),
    .data(tx_byte), .busy(tx_busy), .bit_o(tx_bit)
  );

  swe_ctl #(.BIT_CYCLES(BIT_CYCLES), .DATA_BITS(DATA_BITS), .GAP_BITS(GAP_BITS)) ctl_i (
    .clk(clk), .rst_n(rst_n),
    .rx_busy(rx_busy), .rx_ok(rx_ok), .rx_brk(rx_brk), .rx_byte(rx_byte),
    .tx_busy(tx_busy), .rx_en(rx_en), .tx_start(tx_start), .tx_brk(tx_brk),
    .tx_byte(tx_byte), .force_hi(force_hi),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .brk_det(brk_det)
  );

  assign line_oe  = tx_busy | force_hi;
  assign line_out = force_hi | tx_bit;

  AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(line_oe) |-> !rx_busy); // R9
endmodule

// File: tb/sw_echo_xcvr_tb_top.sv
`timescale 1ns/1ps
module sw_echo_xcvr_tb_top;
  localparam int B = 256;
  localparam int H = B / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_line = 1'b1;
  logic       line_in, line_oe, line_out;
  logic       rx_valid, rx_ready = 1'b1, tx_valid = 1'b0, tx_ready, brk_det;
  logic [7:0] rx_data, tx_data = 8'h00;

  int cyc = 0, n_chk = 0, n_fail = 0;
  int rx_cnt = 0, brk_cnt = 0, oe_rise = -1;
  logic [7:0] rx_last = 8'h00;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign line_in = line_oe ? line_out : host_line;

  sw_echo_xcvr dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .line_oe(line_oe), .line_out(line_out),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .brk_det(brk_det)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (line_oe && !oe_prev) oe_rise = cyc;
    oe_prev = line_oe;
    if (brk_det) brk_cnt++;
    if (rx_valid && rx_ready) begin
      rx_cnt++;
      rx_last = rx_data;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic send_bits(input logic [9:0] v, input int n, input int low_len, output int t0);
    @(negedge clk);
    t0 = cyc;
    for (int i = 0; i < n; i++) begin
      host_line = v[i];
      repeat ((low_len > 0 && i == 0) ? low_len : B) @(negedge clk);
    end
    host_line = 1'b1;
  endtask

  task automatic grab_frame(input logic [7:0] exp, input int t_exp, input string req);
    int ts, guard;
    logic [9:0] got;
    guard = 0;
    while (!line_oe && guard < 16 * B) begin
      @(negedge clk);
      guard++;
    end
    ts = cyc;
    chk((ts - t_exp) <= 10 && (t_exp - ts) <= 10, req, "frame start cycle", ts, t_exp);
    for (int i = 0; i < 10; i++) begin
      wait_until(ts + H + i * B);
      got[i] = line_out;
      chk(line_oe == 1'b1, "R9", "oe during frame", int'(line_oe), 1);
    end
    chk(got[0] == 1'b0, req, "start bit", int'(got[0]), 0);
    chk(got[9] == 1'b1, req, "stop bit", int'(got[9]), 1);
    chk(got[8:1] == exp, req, "frame data", int'(got[8:1]), int'(exp));
    wait_until(ts + 10 * B + 4);
    chk(line_oe == 1'b0, "R9", "released after frame", int'(line_oe), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(line_oe == 1'b0, "R1", "oe at reset", int'(line_oe), 0);
    chk(rx_valid == 1'b0, "R1", "rx_valid at reset", int'(rx_valid), 0);
    chk(brk_det == 1'b0, "R1", "brk_det at reset", int'(brk_det), 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready at reset", int'(tx_ready), 1);
  endtask

  task automatic t_echo(input logic [7:0] d);
    int t0, n0;
    n0 = rx_cnt;
    send_bits({1'b1, d, 1'b0}, 10, 0, t0);
    wait_until(t0 + 10 * B + H);
    chk(line_oe == 1'b0, "R4", "line released in gap", int'(line_oe), 0);
    chk(rx_cnt == n0 + 1, "R2", "byte delivered", rx_cnt, n0 + 1);
    chk(rx_last == d, "R2", "received data", int'(rx_last), int'(d));
    grab_frame(d, t0 + 11 * B + H, "R4");
  endtask

  task automatic t_break();
    int t0, n0, b0, r;
    n0 = rx_cnt;
    b0 = brk_cnt;
    send_bits(10'h000, 10, 0, t0);
    r = oe_rise;
    chk(brk_cnt == b0 + 1, "R5", "break pulses", brk_cnt, b0 + 1);
    chk((r - (t0 + 9 * B + H)) <= 10 && (t0 + 9 * B + H - r) <= 10, "R5", "force start", r, t0 + 9 * B + H);
    wait_until(r + B);
    chk(line_oe && line_out, "R5", "forced high", int'(line_out), 1);
    wait_until(r + 2 * B + H);
    chk(line_oe && !line_out, "R5", "break echo first low", int'(line_out), 0);
    wait_until(r + 11 * B + H);
    chk(line_oe && !line_out, "R5", "break echo last low", int'(line_out), 0);
    wait_until(r + 12 * B + H);
    chk(line_oe == 1'b0, "R5", "released after break", int'(line_oe), 0);
    chk(rx_cnt == n0, "R5", "no byte from break", rx_cnt, n0);
  endtask

  task automatic t_ferr();
    int t0, n0, b0, r0;
    n0 = rx_cnt; b0 = brk_cnt; r0 = oe_rise;
    send_bits({1'b0, 8'h81, 1'b0}, 10, 0, t0);
    wait_until(t0 + 14 * B);
    chk(oe_rise == r0, "R6", "no reply on framing error", oe_rise, r0);
    chk(rx_cnt == n0, "R6", "no byte on framing error", rx_cnt, n0);
    chk(brk_cnt == b0, "R6", "no break on framing error", brk_cnt, b0);
  endtask

  task automatic t_glitch();
    int t0, n0, r0;
    n0 = rx_cnt; r0 = oe_rise;
    send_bits(10'h000, 1, B / 4, t0);
    wait_until(t0 + 12 * B);
    chk(oe_rise == r0, "R7", "glitch no reply", oe_rise, r0);
    chk(rx_cnt == n0, "R7", "glitch no byte", rx_cnt, n0);
  endtask

  task automatic t_backpressure();
    int t0, n0;
    @(posedge clk); #1 rx_ready = 1'b0;
    n0 = rx_cnt;
    send_bits({1'b1, 8'hA5, 1'b0}, 10, 0, t0);
    grab_frame(8'hA5, t0 + 11 * B + H, "R4");
    chk(rx_valid && rx_data == 8'hA5, "R3", "held byte", int'(rx_data), 8'hA5);
    send_bits({1'b1, 8'h5A, 1'b0}, 10, 0, t0);
    grab_frame(8'h5A, t0 + 11 * B + H, "R3");
    chk(rx_valid && rx_data == 8'hA5, "R3", "older byte kept", int'(rx_data), 8'hA5);
    @(posedge clk); #1 rx_ready = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(rx_valid == 1'b0, "R3", "valid drops after accept", int'(rx_valid), 0);
    chk(rx_cnt == n0 + 1 && rx_last == 8'hA5, "R3", "single delivery", rx_cnt, n0 + 1);
  endtask

  task automatic t_tx_req(input logic [7:0] d);
    int te;
    @(negedge clk);
    chk(tx_ready == 1'b1, "R8", "ready when idle", int'(tx_ready), 1);
    tx_valid = 1'b1; tx_data = d;
    @(negedge clk);
    tx_valid = 1'b0;
    te = cyc;
    chk(tx_ready == 1'b0, "R8", "ready low while sending", int'(tx_ready), 0);
    grab_frame(d, te, "R8");
  endtask

  task automatic t_ignore();
    int t0, n0, r;
    n0 = rx_cnt;
    send_bits({1'b1, 8'h11, 1'b0}, 10, 0, t0);
    host_line = 1'b0;
    repeat (B) @(negedge clk);
    host_line = 1'b1;
    grab_frame(8'h11, t0 + 11 * B + H, "R4");
    r = oe_rise;
    wait_until(cyc + 12 * B);
    chk(rx_cnt == n0 + 1, "R9", "gap pulse not received", rx_cnt, n0 + 1);
    chk(oe_rise == r, "R9", "no extra reply", oe_rise, r);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    repeat (4) @(negedge clk);
    t_echo(8'hA5);          // R2 R4 R10
    t_echo(8'h3C);
    t_echo(8'h00);
    t_echo(8'hFF);
    t_break();              // R5
    t_ferr();               // R6
    t_glitch();             // R7
    t_echo(8'h81);
    t_backpressure();       // R3
    t_tx_req(8'hC3);        // R8
    t_ignore();             // R9
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule